// File: doc/BRIEF.md
# Variable-Page-Size Associative Translation Buffer

This block is a fully associative translation buffer for a memory management unit with 64-bit virtual and 41-bit physical addresses. Each slot holds a virtual tag, a 13-bit context and a translation word. Every slot carries its own page size, so every slot builds its own compare mask. A lookup compares all slots at once. One clock later it returns the physical page, the granted permissions and a byte-swap flag, or a miss, access-fault or protection-fault code.

Faults load a fault status register, a fault address register and a tag-access register. Misses load only the tag-access register, which the miss handler uses. The same array serves data requests and instruction fetches. Software fills slots through a one-cycle write port and can read any slot's translation word back through a read port. The replacement policy and the miss handler are outside the block.

Top module: `vpt_tlb`

## Requirements
- R1: The 2-bit size code at bits 62:61 of the translation word selects a page of 8 KB, 64 KB, 512 KB or 4 MB, for codes 0 to 3. The page mask of a slot is the two's complement of 8192 shifted left by three times its code.
- R2: A slot hits when its valid bit (bit 63) is set, the request address and the tag agree under the slot's mask, and either its global bit (bit 53) is set or its context equals the request context. The result appears on the `rsp_*` outputs one clock after `req_valid`. `rsp_fault` encodes 0 none, 1 miss, 2 access fault, 3 protection fault.
- R3: The physical address takes the translation word's bits above the mask and the request's bits below it. It keeps bits 40:13 and forces bits 12:0 to zero.
- R4: `req_ctx_sel` selects the data context: 0 primary, 1 secondary, 2 or 3 nucleus (context 0). A fetch uses the primary context when `req_tl_nz` is 0 and the nucleus context otherwise.
- R5: A hit can raise one or more access-fault flags at once. A user access to a privileged page (bit 60) sets status bit 7. A no-fault load (`req_kind`=2) to a side-effect page (bit 58) sets bit 8. Any other data access to a no-fault-only page (bit 57) sets bit 9. Any of these flags gives an access fault.
- R6: A store (`req_kind`=1) to a page whose writable bit (bit 59) is clear gives a protection fault, but only when no access fault applies.
- R7: A hit without a fault sets the slot's used bit (bit 54). A data hit grants read, plus write when bit 59 is set. A fetch hit grants execute only.
- R8: On any miss or fault, tag-access takes the request address with bits 12:0 replaced by the context. A miss leaves the status and fault address registers unchanged. A data fault loads the fault address register.
- R9: A fault loads the status register. Bit 0 is valid. Bit 1 is overwrite, set when valid was already set and `stat_ack` is not asserted in that cycle. Bits 3:2 give the context type (0 primary, 1 secondary, 2 nucleus). Bit 4 marks a store, bit 5 a no-fault load, bit 6 privileged mode, and bit 10 a fetch. `stat_ack` alone clears the register.
- R10: A data hit without a fault on a slot with the invert-endian bit (bit 56) set raises `rsp_bswap`.
- R11: The write port loads tag, context and translation word into slot `wr_idx` in one clock. When several slots hit, the lowest-numbered one wins.
- R12: A slot write and a used-bit update aimed at the same slot in the same clock leave the written word. A lookup in that clock sees the slot's previous contents.
- R13: After reset, all slots are invalid and every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | 6 | Slot to write |
| wr_va | input | 64 | Virtual tag to write |
| wr_ctx | input | 13 | Context to write |
| wr_tte | input | 64 | Translation word to write |
| rd_idx | input | 6 | Slot to read back |
| rd_tte | output | 64 | Translation word of slot `rd_idx` |
| req_valid | input | 1 | Lookup request |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_kind | input | 2 | Data access kind: 0 load, 1 store, 2 no-fault load |
| req_ctx_sel | input | 2 | Data context select |
| req_user | input | 1 | Access is in user mode |
| req_priv_mode | input | 1 | Processor privileged mode, recorded in status |
| req_tl_nz | input | 1 | Trap level is non-zero |
| req_va | input | 64 | Virtual address |
| primary_ctx | input | 13 | Primary context |
| secondary_ctx | input | 13 | Secondary context |
| stat_ack | input | 1 | Status read acknowledge |
| rsp_valid | output | 1 | Response valid |
| rsp_fault | output | 2 | Outcome code |
| rsp_pa | output | 41 | Physical page address |
| rsp_rd | output | 1 | Read granted |
| rsp_wr | output | 1 | Write granted |
| rsp_ex | output | 1 | Execute granted |
| rsp_bswap | output | 1 | Byte swap required |
| fault_status | output | 11 | Fault status register |
| fault_addr | output | 64 | Fault address register |
| tag_access | output | 64 | Tag-access register |

## Verification
Two functions can land on the same slot in the same clock. A refill through the write port can coincide with the used-bit update of a lookup that hits that slot. The bench provokes this by writing a new word into the slot that the lookup is hitting in that same cycle. It then judges two things: the response carries the old physical page, and the read-back port shows the new word with its used bit clear. A second overlap is a new fault arriving in the cycle that acknowledges the status register. The bench checks that no overwrite is reported in that case.

// File: rtl/vpt_pkg.sv
package vpt_pkg;
  localparam int VA_W    = 64;
  localparam int PA_W    = 41;
  localparam int CTX_W   = 13;
  localparam int PG_BITS = 13;

  localparam int TTE_V     = 63;
  localparam int TTE_SZ_HI = 62;
  localparam int TTE_SZ_LO = 61;
  localparam int TTE_PRIV  = 60;
  localparam int TTE_WR    = 59;
  localparam int TTE_SE    = 58;
  localparam int TTE_NFO   = 57;
  localparam int TTE_IE    = 56;
  localparam int TTE_LOCK  = 55;
  localparam int TTE_USED  = 54;
  localparam int TTE_GLB   = 53;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0, FLT_MISS = 2'd1, FLT_ACCESS = 2'd2, FLT_PROT = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    KIND_LOAD = 2'd0, KIND_STORE = 2'd1, KIND_NOFAULT = 2'd2, KIND_RSVD = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    CT_PRIMARY = 2'd0, CT_SECONDARY = 2'd1, CT_NUCLEUS = 2'd2, CT_NONE = 2'd3
  } ctx_type_e;

  typedef struct packed {
    logic       fetch;
    logic       ft_nfo;
    logic       ft_nfe;
    logic       ft_priv;
    logic       priv_mode;
    logic       nofault;
    logic       write;
    logic [1:0] ctx_type;
    logic       ovw;
    logic       valid;
  } stat_t;

  // compare mask of a slot from its size code
  function automatic logic [VA_W-1:0] page_mask(input logic [1:0] sz);
    logic [VA_W-1:0] span;
    span = 64'd8192 << (3 * sz);
    return ~(span - 64'd1);
  endfunction

  // physical page: slot bits above the mask, request bits below it
  function automatic logic [PA_W-1:0] phys_of(input logic [63:0] tte,
                                               input logic [VA_W-1:0] va,
                                               input logic [VA_W-1:0] mask);
    logic [VA_W-1:0] mix;
    mix = (tte & mask) | (va & ~mask);
    return {mix[PA_W-1:PG_BITS], {PG_BITS{1'b0}}};
  endfunction
endpackage

// File: rtl/vpt_entry_store.sv
module vpt_entry_store
  import vpt_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VA_W-1:0]  wr_va,
  input  logic [CTX_W-1:0] wr_ctx,
  input  logic [63:0]      wr_tte,
  input  logic             used_set,
  input  logic [IDX_W-1:0] used_idx,
  input  logic [VA_W-1:0]  lk_va,
  input  logic [CTX_W-1:0] lk_ctx,
  output logic [ENTRIES-1:0] match_vec,
  output logic [63:0]      tte_arr  [ENTRIES],
  output logic [VA_W-1:0]  mask_arr [ENTRIES]
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic [VA_W-1:0]  tag_va_q;
    logic [CTX_W-1:0] tag_ctx_q;
    logic [63:0]      tte_q;
    logic             wr_here;
    logic             used_here;

    assign wr_here   = wr_en && (wr_idx == IDX_W'(g));
    assign used_here = used_set && (used_idx == IDX_W'(g));

    // a refill outranks the used-bit update on the same slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_va_q  <= '0;
        tag_ctx_q <= '0;
        tte_q     <= '0;
      end else if (wr_here) begin
        tag_va_q  <= wr_va;
        tag_ctx_q <= wr_ctx;
        tte_q     <= wr_tte;
      end else if (used_here) begin
        tte_q[TTE_USED] <= 1'b1;
      end
    end

    assign mask_arr[g]  = page_mask(tte_q[TTE_SZ_HI:TTE_SZ_LO]);
    assign match_vec[g] = tte_q[TTE_V]
                          && ((lk_va & mask_arr[g]) == (tag_va_q & mask_arr[g]))
                          && (tte_q[TTE_GLB] || (tag_ctx_q == lk_ctx));
    assign tte_arr[g]   = tte_q;

    p_refill_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_here |=> (tte_q == $past(wr_tte)));
    p_used_sticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (used_here && !wr_here) |=> tte_q[TTE_USED]);
  end
endmodule

// File: rtl/vpt_pick.sv
module vpt_pick #(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] match_vec,
  output logic               any_hit,
  output logic [IDX_W-1:0]   win_idx
);
  logic [ENTRIES-1:0] below_win;

  // scan downward so that the lowest matching slot is kept last
  always_comb begin
    any_hit = 1'b0;
    win_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        any_hit = 1'b1;
        win_idx = IDX_W'(i);
      end
    end
  end

  assign below_win = (ENTRIES'(1) << win_idx) - ENTRIES'(1);

  always_comb begin
    if (any_hit) begin
      p_winner_matches_r11: assert (match_vec[win_idx]);
      p_winner_lowest_r11: assert ((match_vec & below_win) == '0);
    end
  end
endmodule

// File: rtl/vpt_fault_unit.sv
module vpt_fault_unit
  import vpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_fetch,
  input  logic [1:0]       req_kind,
  input  logic             req_user,
  input  logic             req_priv_mode,
  input  logic [1:0]       req_ctx_type,
  input  logic [CTX_W-1:0] req_ctx,
  input  logic [VA_W-1:0]  req_va,
  input  logic             any_hit,
  input  logic [63:0]      hit_tte,
  input  logic [VA_W-1:0]  hit_mask,
  input  logic             stat_ack,
  output logic             used_set,
  output logic             rsp_valid,
  output logic [1:0]       rsp_fault,
  output logic [PA_W-1:0]  rsp_pa,
  output logic             rsp_rd,
  output logic             rsp_wr,
  output logic             rsp_ex,
  output logic             rsp_bswap,
  output stat_t            stat_q,
  output logic [VA_W-1:0]  far_q,
  output logic [VA_W-1:0]  tag_q
);
  logic  is_st, is_nf, f_priv, f_nfe, f_nfo, acc_flt, prot_flt;
  logic  ok_hit, fault_ev, miss_ev;
  stat_t stat_new;

  always_comb begin
    is_st    = !req_fetch && (req_kind == KIND_STORE);
    is_nf    = !req_fetch && (req_kind == KIND_NOFAULT);
    f_priv   = hit_tte[TTE_PRIV] && req_user;
    f_nfe    = is_nf && hit_tte[TTE_SE];
    f_nfo    = !req_fetch && !is_nf && hit_tte[TTE_NFO];
    acc_flt  = f_priv || f_nfe || f_nfo;
    prot_flt = !acc_flt && is_st && !hit_tte[TTE_WR];
    ok_hit   = req_valid && any_hit && !acc_flt && !prot_flt;
    fault_ev = req_valid && any_hit && (acc_flt || prot_flt);
    miss_ev  = req_valid && !any_hit;

    stat_new.valid     = 1'b1;
    stat_new.ovw       = stat_q.valid && !stat_ack;
    stat_new.ctx_type  = req_ctx_type;
    stat_new.write     = is_st;
    stat_new.nofault   = is_nf;
    stat_new.priv_mode = req_priv_mode;
    stat_new.ft_priv   = f_priv;
    stat_new.ft_nfe    = f_nfe;
    stat_new.ft_nfo    = f_nfo;
    stat_new.fetch     = req_fetch;
  end

  assign used_set = ok_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= FLT_NONE;
      rsp_pa    <= '0;
      rsp_rd    <= 1'b0;
      rsp_wr    <= 1'b0;
      rsp_ex    <= 1'b0;
      rsp_bswap <= 1'b0;
      stat_q    <= '0;
      far_q     <= '0;
      tag_q     <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= miss_ev ? FLT_MISS
                 : fault_ev ? (acc_flt ? FLT_ACCESS : FLT_PROT) : FLT_NONE;
      rsp_pa    <= ok_hit ? phys_of(hit_tte, req_va, hit_mask) : '0;
      rsp_rd    <= ok_hit && !req_fetch;
      rsp_wr    <= ok_hit && !req_fetch && hit_tte[TTE_WR];
      rsp_ex    <= ok_hit && req_fetch;
      rsp_bswap <= ok_hit && !req_fetch && hit_tte[TTE_IE];
      if (fault_ev)      stat_q <= stat_new;
      else if (stat_ack) stat_q <= '0;
      if (fault_ev && !req_fetch) far_q <= req_va;
      if (fault_ev || miss_ev)    tag_q <= {req_va[VA_W-1:PG_BITS], req_ctx};
    end
  end

  p_miss_no_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault == FLT_MISS) |-> !(rsp_rd || rsp_wr || rsp_ex || rsp_bswap));
  p_access_flagged_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault == FLT_ACCESS) |-> (stat_q.ft_priv || stat_q.ft_nfe || stat_q.ft_nfo));
  p_prot_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault == FLT_PROT) |-> (stat_q.write && !stat_q.ft_priv && !stat_q.ft_nfe && !stat_q.ft_nfo));
  p_miss_keeps_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_ev && !stat_ack) |=> ($stable(stat_q) && $stable(far_q)));
  p_tag_carries_ctx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_ev || miss_ev) |=> (tag_q[PG_BITS-1:0] == $past(req_ctx)));
  p_overwrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_ev && stat_q.valid && !stat_ack) |=> stat_q.ovw);
endmodule

// File: rtl/vpt_tlb.sv
module vpt_tlb
  import vpt_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [63:0]      wr_va,
  input  logic [12:0]      wr_ctx,
  input  logic [63:0]      wr_tte,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [63:0]      rd_tte,
  input  logic             req_valid,
  input  logic             req_fetch,
  input  logic [1:0]       req_kind,
  input  logic [1:0]       req_ctx_sel,
  input  logic             req_user,
  input  logic             req_priv_mode,
  input  logic             req_tl_nz,
  input  logic [63:0]      req_va,
  input  logic [12:0]      primary_ctx,
  input  logic [12:0]      secondary_ctx,
  input  logic             stat_ack,
  output logic             rsp_valid,
  output logic [1:0]       rsp_fault,
  output logic [40:0]      rsp_pa,
  output logic             rsp_rd,
  output logic             rsp_wr,
  output logic             rsp_ex,
  output logic             rsp_bswap,
  output logic [10:0]      fault_status,
  output logic [63:0]      fault_addr,
  output logic [63:0]      tag_access
);
  logic [CTX_W-1:0]   lk_ctx;
  logic [1:0]         lk_ct;
  logic [ENTRIES-1:0] match_vec;
  logic [63:0]        tte_arr  [ENTRIES];
  logic [VA_W-1:0]    mask_arr [ENTRIES];
  logic               any_hit, used_set;
  logic [IDX_W-1:0]   win_idx;
  stat_t              stat_q;

  // context used for the compare and its class for the status register
  always_comb begin
    if (req_fetch) begin
      lk_ctx = req_tl_nz ? '0 : primary_ctx;
      lk_ct  = req_tl_nz ? CT_NUCLEUS : CT_PRIMARY;
    end else begin
      case (req_ctx_sel)
        2'd0:    begin lk_ctx = primary_ctx;   lk_ct = CT_PRIMARY;   end
        2'd1:    begin lk_ctx = secondary_ctx; lk_ct = CT_SECONDARY; end
        default: begin lk_ctx = '0;            lk_ct = CT_NUCLEUS;   end
      endcase
    end
  end

  vpt_entry_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_va(wr_va), .wr_ctx(wr_ctx), .wr_tte(wr_tte),
    .used_set(used_set), .used_idx(win_idx),
    .lk_va(req_va), .lk_ctx(lk_ctx),
    .match_vec(match_vec), .tte_arr(tte_arr), .mask_arr(mask_arr)
  );

  vpt_pick #(.ENTRIES(ENTRIES)) u_pick (
    .match_vec(match_vec), .any_hit(any_hit), .win_idx(win_idx)
  );

  vpt_fault_unit u_fault (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_fetch(req_fetch), .req_kind(req_kind),
    .req_user(req_user), .req_priv_mode(req_priv_mode),
    .req_ctx_type(lk_ct), .req_ctx(lk_ctx), .req_va(req_va),
    .any_hit(any_hit), .hit_tte(tte_arr[win_idx]), .hit_mask(mask_arr[win_idx]),
    .stat_ack(stat_ack), .used_set(used_set),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
    .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_ex(rsp_ex), .rsp_bswap(rsp_bswap),
    .stat_q(stat_q), .far_q(fault_addr), .tag_q(tag_access)
  );

  assign fault_status = stat_q;
  assign rd_tte       = tte_arr[rd_idx];

  p_resp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_fetch_never_writes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_fetch) |=> !(rsp_rd || rsp_wr || rsp_bswap));
endmodule

// File: tb/vpt_tlb_test.sv
module vpt_tlb_test;
  localparam int ENT = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 0;
  logic [5:0]  wr_idx = 0;
  logic [63:0] wr_va = 0;
  logic [12:0] wr_ctx = 0;
  logic [63:0] wr_tte = 0;
  logic [5:0]  rd_idx = 0;
  logic [63:0] rd_tte;
  logic        req_valid = 0, req_fetch = 0, req_user = 0, req_priv_mode = 0, req_tl_nz = 0;
  logic [1:0]  req_kind = 0, req_ctx_sel = 0;
  logic [63:0] req_va = 0;
  logic [12:0] primary_ctx = 13'd5, secondary_ctx = 13'd7;
  logic        stat_ack = 0;
  logic        rsp_valid, rsp_rd, rsp_wr, rsp_ex, rsp_bswap;
  logic [1:0]  rsp_fault;
  logic [40:0] rsp_pa;
  logic [10:0] fault_status;
  logic [63:0] fault_addr, tag_access;

  vpt_tlb uut (.*);

  always #10 clk = ~clk;

  int    n_checks = 0;
  int    n_fails = 0;
  bit    done = 0;
  string cur_req = "R13";

  // behavioural model state
  bit [63:0] m_va [ENT];
  bit [12:0] m_ctx [ENT];
  bit [63:0] m_tte [ENT];
  bit [10:0] m_stat;
  bit [63:0] m_far, m_tag;
  bit        e_valid, e_rd, e_wr, e_ex, e_bs;
  bit [1:0]  e_fault;
  bit [40:0] e_pa;

  function automatic bit [63:0] mk(int sz, bit pr, bit w, bit se, bit nfo, bit ie,
                                   bit glb, bit [63:0] pa);
    bit [63:0] t = pa;
    t[63] = 1; t[62:61] = 2'(sz); t[60] = pr; t[59] = w; t[58] = se;
    t[57] = nfo; t[56] = ie; t[53] = glb;
    return t;
  endfunction

  task automatic model_step();
    int        win = -1;
    bit [63:0] pg_bytes, msk, mix, t;
    bit [12:0] c;
    bit [1:0]  ct;
    bit        st, nf, fp, fe, fo, acc, prot;
    if (req_fetch) begin
      c = req_tl_nz ? 13'd0 : primary_ctx; ct = req_tl_nz ? 2'd2 : 2'd0;
    end else if (req_ctx_sel == 0) begin c = primary_ctx; ct = 0; end
    else if (req_ctx_sel == 1) begin c = secondary_ctx; ct = 1; end
    else begin c = 0; ct = 2; end
    for (int i = 0; i < ENT; i++) begin
      if (win < 0) begin
        pg_bytes = 64'd8192;
        for (int k = 0; k < int'(m_tte[i][62:61]); k++) pg_bytes = pg_bytes * 8;
        msk = ~(pg_bytes - 1);
        if (m_tte[i][63] && (((req_va ^ m_va[i]) & msk) == 0) &&
            (m_tte[i][53] || m_ctx[i] == c)) win = i;
      end
    end
    e_valid = req_valid; e_fault = 0; e_pa = 0; e_rd = 0; e_wr = 0; e_ex = 0; e_bs = 0;
    acc = 0; prot = 0;
    if (req_valid && win < 0) begin
      e_fault = 1; m_tag = {req_va[63:13], c};
      if (stat_ack) m_stat = 0;
    end else if (req_valid) begin
      t = m_tte[win];
      pg_bytes = 64'd8192;
      for (int k = 0; k < int'(t[62:61]); k++) pg_bytes = pg_bytes * 8;
      msk = ~(pg_bytes - 1);
      st = !req_fetch && req_kind == 1;
      nf = !req_fetch && req_kind == 2;
      fp = t[60] && req_user;
      fe = nf && t[58];
      fo = !req_fetch && !nf && t[57];
      acc = fp || fe || fo;
      prot = !acc && st && !t[59];
      if (acc || prot) begin
        e_fault = acc ? 2 : 3;
        m_stat = {req_fetch, fo, fe, fp, req_priv_mode, nf, st, ct,
                  (m_stat[0] && !stat_ack), 1'b1};
        if (!req_fetch) m_far = req_va;
        m_tag = {req_va[63:13], c};
      end else begin
        mix = (t & msk) | (req_va & ~msk);
        e_pa = {mix[40:13], 13'd0};
        e_rd = !req_fetch; e_wr = !req_fetch && t[59]; e_ex = req_fetch;
        e_bs = !req_fetch && t[56];
        if (stat_ack) m_stat = 0;
      end
    end else if (stat_ack) m_stat = 0;
    // used-bit update first, refill written over it
    if (req_valid && win >= 0 && !acc && !prot) m_tte[win][54] = 1;
    if (wr_en) begin m_va[wr_idx] = wr_va; m_ctx[wr_idx] = wr_ctx; m_tte[wr_idx] = wr_tte; end
  endtask

  task automatic chk(string what, bit [63:0] act, bit [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    chk("rsp_valid", 64'(rsp_valid), 64'(e_valid));
    chk("rsp_fault", 64'(rsp_fault), 64'(e_fault));
    chk("rsp_pa", 64'(rsp_pa), 64'(e_pa));
    chk("rsp_rd", 64'(rsp_rd), 64'(e_rd));
    chk("rsp_wr", 64'(rsp_wr), 64'(e_wr));
    chk("rsp_ex", 64'(rsp_ex), 64'(e_ex));
    chk("rsp_bswap", 64'(rsp_bswap), 64'(e_bs));
    chk("fault_status", 64'(fault_status), 64'(m_stat));
    chk("fault_addr", fault_addr, m_far);
    chk("tag_access", tag_access, m_tag);
    chk("rd_tte", rd_tte, m_tte[rd_idx]);
  endtask

  task automatic put(int idx, bit [63:0] va, bit [12:0] c, bit [63:0] t);
    wr_en = 1; wr_idx = 6'(idx); wr_va = va; wr_ctx = c; wr_tte = t; rd_idx = 6'(idx);
    tick();
    wr_en = 0;
  endtask

  task automatic look(bit f, int kind, int sel, bit u, bit tl, bit [63:0] va);
    req_valid = 1; req_fetch = f; req_kind = 2'(kind); req_ctx_sel = 2'(sel);
    req_user = u; req_priv_mode = !u; req_tl_nz = tl; req_va = va;
    tick();
    req_valid = 0;
  endtask

  initial begin
    for (int i = 0; i < ENT; i++) begin m_va[i] = 0; m_ctx[i] = 0; m_tte[i] = 0; end
    m_stat = 0; m_far = 0; m_tag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R13"; tick();

    cur_req = "R2";
    put(3, 64'h0000_0040_0000_2000, 13'd5, mk(0, 0, 1, 0, 0, 0, 0, 64'h12_3456_0000));
    rd_idx = 3;
    look(0, 0, 0, 0, 0, 64'h0000_0040_0000_2abc);
    primary_ctx = 13'd6;
    look(0, 0, 0, 0, 0, 64'h0000_0040_0000_2abc);
    put(4, 64'h0000_0000_1000_0000, 13'd9, mk(0, 0, 0, 0, 0, 0, 1, 64'h0_0000_4000));
    look(0, 0, 0, 1, 0, 64'h0000_0000_1000_0010);
    primary_ctx = 13'd5;

    cur_req = "R1";
    put(5, 64'h8000_0000, 13'd5, mk(3, 0, 1, 0, 0, 0, 0, 64'h2000_1_0040_0000));
    look(0, 0, 0, 0, 0, 64'h8012_3000);
    look(0, 0, 0, 0, 0, 64'h8040_0000);
    put(6, 64'h0000_0100_0000_0000, 13'd5, mk(1, 0, 1, 0, 0, 0, 0, 64'h0_0777_0000));
    look(0, 0, 0, 0, 0, 64'h0000_0100_0000_e000);
    look(0, 0, 0, 0, 0, 64'h0000_0100_0001_0000);
    put(7, 64'h2000_0000, 13'd5, mk(2, 0, 0, 0, 0, 0, 0, 64'h0_1108_0000));
    look(0, 0, 0, 0, 0, 64'h2007_6000);
    cur_req = "R3";
    look(0, 0, 0, 0, 0, 64'h803f_f000);

    cur_req = "R4";
    put(8, 64'h3000_0000, 13'd7, mk(0, 0, 1, 0, 0, 0, 0, 64'h0_0a00_0000));
    put(9, 64'h3000_0000, 13'd0, mk(0, 0, 1, 0, 0, 0, 0, 64'h0_0b00_0000));
    look(0, 0, 1, 0, 0, 64'h3000_0000);
    look(1, 0, 0, 0, 0, 64'h3000_0000);
    look(1, 0, 0, 0, 1, 64'h3000_0000);
    look(0, 0, 2, 0, 0, 64'h3000_0000);

    cur_req = "R5";
    put(10, 64'h4000_0000, 13'd5, mk(0, 1, 1, 1, 0, 0, 0, 64'h0_0c00_0000));
    look(0, 2, 0, 1, 0, 64'h4000_0000);
    look(0, 1, 0, 1, 0, 64'h4000_0000);
    put(11, 64'h4100_0000, 13'd5, mk(0, 0, 0, 0, 1, 0, 0, 64'h0_0d00_0000));
    look(0, 1, 0, 0, 0, 64'h4100_0000);
    look(0, 2, 0, 0, 0, 64'h4100_0000);

    cur_req = "R6";
    put(12, 64'h4200_0000, 13'd5, mk(0, 0, 0, 0, 0, 0, 0, 64'h0_0e00_0000));
    look(0, 1, 0, 0, 0, 64'h4200_0000);
    put(13, 64'h4400_0000, 13'd5, mk(0, 1, 0, 0, 0, 0, 0, 64'h0_0f00_0000));
    look(0, 1, 0, 1, 0, 64'h4400_0000);

    cur_req = "R8";
    look(0, 0, 1, 0, 0, 64'h7777_0000);
    look(1, 0, 0, 0, 1, 64'h7778_0000);

    cur_req = "R9";
    stat_ack = 1; tick(); stat_ack = 0;
    look(0, 1, 0, 0, 0, 64'h4200_0000);
    look(0, 1, 0, 0, 0, 64'h4200_0000);
    stat_ack = 1;
    look(1, 0, 0, 1, 0, 64'h4400_0000);
    stat_ack = 0;

    cur_req = "R10";
    put(14, 64'h4300_0000, 13'd5, mk(0, 0, 1, 0, 0, 1, 0, 64'h0_1000_0000));
    look(0, 0, 0, 0, 0, 64'h4300_0000);
    cur_req = "R7";
    look(1, 0, 0, 0, 0, 64'h4300_0000);
    rd_idx = 5;
    look(0, 1, 0, 0, 0, 64'h8000_1000);

    cur_req = "R11";
    put(1, 64'h5000_0000, 13'd5, mk(0, 0, 1, 0, 0, 0, 0, 64'h0_1100_0000));
    put(2, 64'h5000_0000, 13'd5, mk(0, 0, 1, 0, 0, 0, 0, 64'h0_1200_0000));
    look(0, 0, 0, 0, 0, 64'h5000_0000);
    put(1, 64'h5000_0000, 13'd5, 64'd0);
    look(0, 0, 0, 0, 0, 64'h5000_0000);

    cur_req = "R12";
    rd_idx = 2;
    wr_en = 1; wr_idx = 2; wr_va = 64'h5000_0000; wr_ctx = 13'd5;
    wr_tte = mk(0, 0, 0, 0, 0, 0, 0, 64'h0_1300_0000);
    look(0, 0, 0, 0, 0, 64'h5000_0000);
    wr_en = 0;
    look(0, 0, 0, 0, 0, 64'h5000_0000);

    repeat (2) tick();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule